// File: doc/BRIEF.md
# Key Matrix Change Event Encoder

This block sits behind a keyboard matrix scanner and turns raw column samples into discrete key events. For each of its columns it remembers the last 16-bit sense word. When a fresh sample for a column arrives, only the row bits that differ from the remembered word give events. Each event says whether the key went down or came up, and carries a key code built from the row and the column.

Sense lines are active low, so a bit that now reads 0 is a press and a bit that now reads 1 is a release. Events leave one at a time over a valid/ready handshake, lowest row first. The sample input is held off until the last event of the current sample has been taken. A synchronous clear returns every column's history to the power-up pattern and drops any events still waiting. Scanning, debouncing and translation of key codes happen elsewhere.

Top module: `keymx_evt_enc`

## Requirements
- R1: After reset every column's stored word is 0xDFFF, no event is offered and `smp_ready` is high.
- R2: A sample equal to the stored word of its column gives no event, and `smp_ready` stays high in the next cycle.
- R3: A sample that differs from its column's stored word replaces that word, so a later sample is compared against it.
- R4: The events of one sample come out in ascending row order, from row 0 up to row 15.
- R5: `evt_press` is 1 when the changed bit reads 0 in the new sample, and 0 when it reads 1.
- R6: `evt_code` equals row × 8 + column: bits [6:3] hold the row and bits [2:0] the column.
- R7: Each accepted handshake (`evt_valid` and `evt_ready` both high) consumes exactly one event. While `evt_ready` is low the offered event holds steady. `smp_ready` is low while any event of the current sample is pending. The first event is offered in the cycle after the sample is accepted.
- R8: While `clr` is high, `smp_ready` is low. One cycle after `clr`, no event is pending and every stored word is 0xDFFF again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| clr | input | 1 | Reload all column history with 0xDFFF and drop pending events |
| smp_valid | input | 1 | A column sample is offered |
| smp_ready | output | 1 | The block can take a sample |
| smp_col | input | 3 | Column index of the sample |
| smp_word | input | 16 | Active-low sense word of the sample |
| evt_valid | output | 1 | An event is offered |
| evt_ready | input | 1 | The consumer takes the offered event |
| evt_press | output | 1 | 1 for press, 0 for release |
| evt_code | output | 7 | Key code, row × 8 + column |

## Verification
If the history of a column is wrong, the error does not show when that history is written. It shows at the next sample for that column, as a missing event, an extra event or a flipped press flag, so the bench revisits every column right after changing it. A fault in the pending-row mask shows within one handshake, as a skipped or repeated row code or as `smp_ready` rising too early. A wrong clear shows in the cycle after `clr`, as a leftover event. It also shows when a sample equal to 0xDFFF then produces events.

// File: rtl/keymx_pkg.sv
package keymx_pkg;
  // Default geometry of the sense matrix
  localparam int unsigned KM_COLS = 8;
  localparam int unsigned KM_ROWS = 16;
  // Power-up history pattern: row 13 of every column reads as pressed
  localparam logic [KM_ROWS-1:0] KM_IDLE_WORD = 16'hDFFF;
endpackage

// File: rtl/keymx_hist.sv
module keymx_hist #(
  parameter int unsigned        N_COLS   = 8,
  parameter int unsigned        N_ROWS   = 16,
  parameter logic [N_ROWS-1:0]  RST_WORD = '1,
  localparam int unsigned       CLW      = $clog2(N_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CLW-1:0]    rd_col,
  output logic [N_ROWS-1:0] rd_word,
  input  logic              wr_en,
  input  logic [CLW-1:0]    wr_col,
  input  logic [N_ROWS-1:0] wr_word
);
  logic [N_COLS-1:0][N_ROWS-1:0] col_words;

  for (genvar g = 0; g < N_COLS; g++) begin : g_col
    logic [N_ROWS-1:0] word_q;
    logic [N_ROWS-1:0] word_d;
    logic              word_en;

    always_comb begin
      word_en = clr | (wr_en & (wr_col == CLW'(g)));
      word_d  = clr ? RST_WORD : wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= RST_WORD;
      else if (word_en) word_q <= word_d;
    end

    assign col_words[g] = word_q;
  end

  assign rd_word = col_words[rd_col];
endmodule

// File: rtl/keymx_prio.sv
module keymx_prio #(
  parameter int unsigned  N_ROWS = 16,
  localparam int unsigned RW     = $clog2(N_ROWS)
) (
  input  logic [N_ROWS-1:0] req,
  output logic [N_ROWS-1:0] grant,
  output logic [RW-1:0]     grant_idx
);
  // Lowest set bit wins
  assign grant = req & (~req + N_ROWS'(1));

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < N_ROWS; i++) begin
      if (grant[i]) grant_idx = grant_idx | RW'(i);
    end
  end
endmodule

// File: rtl/keymx_pend.sv
module keymx_pend #(
  parameter int unsigned  N_COLS = 8,
  parameter int unsigned  N_ROWS = 16,
  localparam int unsigned CLW    = $clog2(N_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [N_ROWS-1:0] ld_mask,
  input  logic [N_ROWS-1:0] ld_word,
  input  logic [CLW-1:0]    ld_col,
  input  logic              take,
  input  logic [N_ROWS-1:0] take_bit,
  output logic [N_ROWS-1:0] mask,
  output logic [N_ROWS-1:0] word,
  output logic [CLW-1:0]    col
);
  logic [N_ROWS-1:0] mask_q, mask_d, word_q;
  logic [CLW-1:0]    col_q;
  logic              mask_en, info_en;

  always_comb begin
    mask_en = clr | load | take;
    info_en = load & ~clr;
    mask_d  = mask_q;
    if (clr)       mask_d = '0;
    else if (load) mask_d = ld_mask;
    else if (take) mask_d = mask_q & ~take_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      col_q  <= '0;
    end else if (info_en) begin
      word_q <= ld_word;
      col_q  <= ld_col;
    end
  end

  assign mask = mask_q;
  assign word = word_q;
  assign col  = col_q;
endmodule

// File: rtl/keymx_evt_enc.sv
module keymx_evt_enc
  import keymx_pkg::*;
#(
  parameter int unsigned  N_COLS = KM_COLS,
  parameter int unsigned  N_ROWS = KM_ROWS,
  localparam int unsigned CLW    = $clog2(N_COLS),
  localparam int unsigned RW     = $clog2(N_ROWS),
  localparam int unsigned CW     = $clog2(N_COLS * N_ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [CLW-1:0]    smp_col,
  input  logic [N_ROWS-1:0] smp_word,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic              evt_press,
  output logic [CW-1:0]     evt_code
);
  logic [N_ROWS-1:0] hist_word, diff, pend_mask, pend_word, grant;
  logic [CLW-1:0]    pend_col;
  logic [RW-1:0]     grant_idx;
  logic              busy, accept, changed, take;

  always_comb begin
    busy      = |pend_mask;
    smp_ready = ~busy & ~clr;
    accept    = smp_valid & smp_ready;
    diff      = smp_word ^ hist_word;
    changed   = accept & (|diff);
    evt_valid = busy;
    take      = evt_valid & evt_ready;
    evt_press = ~|(pend_word & grant);
    evt_code  = CW'(grant_idx) * CW'(N_COLS) + CW'(pend_col);
  end

  keymx_hist #(
    .N_COLS   (N_COLS),
    .N_ROWS   (N_ROWS),
    .RST_WORD (N_ROWS'(KM_IDLE_WORD))
  ) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .rd_col  (smp_col),
    .rd_word (hist_word),
    .wr_en   (changed),
    .wr_col  (smp_col),
    .wr_word (smp_word)
  );

  keymx_pend #(
    .N_COLS (N_COLS),
    .N_ROWS (N_ROWS)
  ) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .load     (changed),
    .ld_mask  (diff),
    .ld_word  (smp_word),
    .ld_col   (smp_col),
    .take     (take),
    .take_bit (grant),
    .mask     (pend_mask),
    .word     (pend_word),
    .col      (pend_col)
  );

  keymx_prio #(
    .N_ROWS (N_ROWS)
  ) u_prio (
    .req       (pend_mask),
    .grant     (grant),
    .grant_idx (grant_idx)
  );
endmodule

// File: rtl/keymx_evt_enc_chk.sv
module keymx_evt_enc_chk #(
  parameter int unsigned  N_COLS = 8,
  parameter int unsigned  N_ROWS = 16,
  localparam int unsigned CW     = $clog2(N_COLS * N_ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          smp_ready,
  input logic          evt_valid,
  input logic          evt_ready,
  input logic          evt_press,
  input logic [CW-1:0] evt_code
);
  AST_INPUT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !smp_ready); // R7

  AST_EVENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code) && $stable(evt_press))); // R7

  AST_CLEAR_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!evt_valid && !$past(smp_ready))); // R8

  AST_ROWS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (evt_valid && evt_ready) |=> (!evt_valid ||
      ((evt_code / CW'(N_COLS)) > ($past(evt_code) / CW'(N_COLS)) &&
       (evt_code % CW'(N_COLS)) == ($past(evt_code) % CW'(N_COLS))))); // R4
endmodule

bind keymx_evt_enc keymx_evt_enc_chk #(.N_COLS(N_COLS), .N_ROWS(N_ROWS)) u_chk (.*);

// File: tb/test_keymx_evt_enc.sv
`timescale 1ns/1ps
module test_keymx_evt_enc;
  logic        clk, rst_n, clr, smp_valid, smp_ready, evt_valid, evt_ready, evt_press;
  logic [2:0]  smp_col;
  logic [15:0] smp_word;
  logic [6:0]  evt_code;

  int n_chk = 0;
  int n_bad = 0;
  int stall_n = 0;
  logic [15:0] mdl [8];

  keymx_evt_enc i_keymx_evt_enc (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_col(smp_col), .smp_word(smp_word),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_press(evt_press), .evt_code(evt_code)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge, in the cycle after the sample edge.
  task automatic drain(input int col, input logic [15:0] w, input string ctx);
    logic [15:0] diff;
    diff = w ^ mdl[col];
    for (int row = 0; row < 16; row++) begin
      if (diff[row]) begin
        stall_n++;
        if (stall_n % 3 == 1) begin
          evt_ready = 1'b0;
          #1 check(evt_valid, {"R7 stall ", ctx}, int'(evt_valid), 1);
          @(posedge clk); @(negedge clk);
        end
        evt_ready = 1'b1;
        #1;
        check(evt_valid, {"R7 valid ", ctx}, int'(evt_valid), 1);
        check(!smp_ready, {"R7 held off ", ctx}, int'(smp_ready), 0);
        check(evt_code == 7'(row * 8 + col), {"R4 R6 code ", ctx}, int'(evt_code), row * 8 + col);
        check(evt_press == ~w[row], {"R5 press ", ctx}, int'(evt_press), int'(~w[row]));
        @(posedge clk); @(negedge clk);
        evt_ready = 1'b0;
      end
    end
    #1;
    check(!evt_valid, {"R2 R7 no extra event ", ctx}, int'(evt_valid), 0);
    check(smp_ready, {"R2 R7 ready again ", ctx}, int'(smp_ready), 1);
    mdl[col] = w;
  endtask

  task automatic send(input int col, input logic [15:0] w, input string ctx);
    @(negedge clk);
    smp_col = 3'(col); smp_word = w; smp_valid = 1'b1;
    #1 check(smp_ready, {"R7 ready before sample ", ctx}, int'(smp_ready), 1);
    @(posedge clk); @(negedge clk);
    smp_valid = 1'b0;
    drain(col, w, ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; smp_valid = 1'b0; evt_ready = 1'b0;
    smp_col = '0; smp_word = '0;
    for (int c = 0; c < 8; c++) mdl[c] = 16'hDFFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(!evt_valid, "R1 no event after reset", int'(evt_valid), 0);
    check(smp_ready, "R1 ready after reset", int'(smp_ready), 1);

    // R1: history is 0xDFFF; equal sample is silent, all-ones releases row 13
    for (int c = 0; c < 8; c++) send(c, 16'hDFFF, "R1 idle equal");
    for (int c = 0; c < 8; c++) send(c, 16'hFFFF, "R1 row13 release");

    // R3: single-bit toggle sweep over every row and column, then toggle back
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 16; r++) begin
        send(c, mdl[c] ^ 16'(1 << r), "R3 toggle");
        send(c, mdl[c] ^ 16'(1 << r), "R3 toggle back");
      end

    // R2: repeated sample gives nothing; R4: multi-bit patterns in order
    for (int c = 0; c < 8; c++) begin
      send(c, 16'h0000, "R4 all press");
      send(c, 16'h0000, "R2 repeat");
      send(c, 16'hA5A5, "R4 pattern a");
      send(c, 16'h5A5A, "R4 pattern b");
      send(c, 16'(16'h1234 * (c + 1)), "R4 pattern c");
      send(c, 16'hFFFF, "R4 all release");
    end

    // R8: clear in the middle of a sample's events
    @(negedge clk);
    smp_col = 3'd3; smp_word = 16'hFF0F; smp_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    smp_valid = 1'b0; evt_ready = 1'b1;
    #1 check(evt_code == 7'(4 * 8 + 3), "R8 first event before clear", int'(evt_code), 35);
    @(posedge clk); @(negedge clk);
    evt_ready = 1'b0; clr = 1'b1;
    #1 check(!smp_ready, "R8 ready low during clear", int'(smp_ready), 0);
    @(posedge clk); @(negedge clk);
    clr = 1'b0;
    #1 check(!evt_valid, "R8 events dropped", int'(evt_valid), 0);
    check(smp_ready, "R8 ready after clear", int'(smp_ready), 1);
    for (int c = 0; c < 8; c++) mdl[c] = 16'hDFFF;
    for (int c = 0; c < 8; c++) send(c, 16'hDFFF, "R8 history reloaded");
    send(5, 16'hDFFE, "R8 after clear press");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule